// File: doc/BRIEF.md
# Serial ROM Cache Preload Sequencer

This block fills an instruction cache from a bit-serial boot ROM once reset is released. It enables the ROM and takes one data bit per clock. It turns each run of 293 bits into a single cache line write, and it repeats this for every line index, counting up from 0. After the final line is accepted, it raises a sticky completion flag and lets the core out of its reset hold.

Each line record carries these fields in order: the four even longwords (0, 2, 4, 6), the 21-bit tag, an 8-bit control byte, the four odd longwords (1, 3, 5, 7), and an 8-bit history byte. Every field arrives least significant bit first.

The cache side is a valid/ready stream. When a record is complete, `wr_valid` rises and the whole payload is presented at once. The payload and `wr_valid` then hold until `wr_ready` is seen high at a clock edge. While the port is stalled, the ROM is not advanced and no bit is sampled, so back-pressure of any length loses nothing. The ROM is modelled as a part that presents its next bit after every clock cycle in which `rom_shift` is high, and restarts from bit 0 while `rom_rst` is high.

Top module: `sercache_preload`

## Requirements
- R1: `rom_rst` is 1 during reset, in the first cycle after reset and after the last line is accepted. It is 0 throughout the load, including cycles where a line waits on the write port.
- R2: During loading, one ROM bit is sampled on every clock edge where `rom_shift` is 1. `rom_shift` is never 1 while `rom_rst` is 1, and exactly 293 bits are shifted per line.
- R3: The record fields are taken in this order: lw0, lw2, lw4, lw6 (32 bits each), tag (21 bits), control (8 bits), lw1, lw3, lw5, lw7, history (8 bits).
- R4: Within each field, the first serial bit is bit 0. `wr_lines[32*j +: 32]` holds longword j.
- R5: The control byte is split into `wr_asn` (its bits 5:0, first six serial bits), `wr_match` (its bit 6) and `wr_line_ok` (its bit 7, last serial bit).
- R6: Exactly NUM_LINES writes are issued, with `wr_index` 0, 1, 2 … in that order, one per completed record.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_index` and the payload stay unchanged and `rom_shift` stays 0.
- R8: `done` rises in the cycle after the final write is accepted, stays 1 until reset, and `core_hold` is always its inverse.
- R9: A reset in the middle of a load restarts the load from line 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_rst | output | 1 | ROM reset/enable; low enables the ROM |
| rom_shift | output | 1 | ROM advance strobe; bit sampled at this edge |
| rom_bit | input | 1 | Serial data from the ROM |
| wr_valid | output | 1 | Line write valid |
| wr_ready | input | 1 | Line write ready from cache |
| wr_index | output | IDX_W (8) | Cache line index |
| wr_lines | output | 256 | Longwords 7..0, longword j at bits 32j+31:32j |
| wr_tag | output | 21 | Line tag |
| wr_asn | output | 6 | Address space number |
| wr_match | output | 1 | Address space match flag |
| wr_line_ok | output | 1 | Line valid flag |
| wr_hist | output | 8 | Branch history byte |
| done | output | 1 | Load complete, sticky |
| core_hold | output | 1 | Core held while load is in progress |

## Verification
The first ROM bit is taken at the second rising edge after reset release. Each record then needs exactly 293 shift cycles, and `wr_valid` is visible in the cycle right after the 293rd shift. `done` is due one cycle after the accepting edge. The bench samples every output on the falling edge and counts shift cycles between writes instead of assuming fixed times, so a stall or an extra cycle shows up as a wrong count. During a stall, stability of the payload and of `rom_shift` is checked on each falling edge of the stall window.

// File: rtl/srpl_pkg.sv
package srpl_pkg;
  localparam int LW_W       = 32;
  localparam int NUM_LW     = 8;
  localparam int TAG_W      = 21;
  localparam int CTL_W      = 8;
  localparam int ASN_W      = 6;
  localparam int HIST_W     = 8;
  localparam int NUM_FIELDS = 11;
  localparam int REC_W      = NUM_LW * LW_W + TAG_W + CTL_W + HIST_W;
  localparam int FLD_IDX_W  = $clog2(NUM_FIELDS);
  localparam int BPOS_W     = $clog2(LW_W);

  // serial field slots: 0..3 even longwords, 4 tag, 5 control, 6..9 odd longwords, 10 history
  localparam int SLOT_TAG  = 4;
  localparam int SLOT_CTL  = 5;
  localparam int SLOT_HIST = 10;

  typedef enum logic [1:0] {ST_BOOT, ST_LOAD, ST_PUSH, ST_DONE} load_state_t;

  typedef struct packed {
    logic [HIST_W-1:0]      hist;
    logic                   line_ok;
    logic                   match;
    logic [ASN_W-1:0]       asn;
    logic [TAG_W-1:0]       tag;
    logic [NUM_LW*LW_W-1:0] lws;
  } cache_line_t;

  function automatic int slot_width(input int k);
    if (k == SLOT_TAG) return TAG_W;
    if (k == SLOT_CTL) return CTL_W;
    if (k == SLOT_HIST) return HIST_W;
    return LW_W;
  endfunction

  function automatic int slot_offset(input int k);
    int off;
    off = 0;
    for (int i = 0; i < k; i++) off += slot_width(i);
    return off;
  endfunction

  // longword number to its serial slot
  function automatic int lw_slot(input int j);
    if ((j % 2) == 0) return j / 2;
    return 6 + j / 2;
  endfunction
endpackage

// File: rtl/srpl_field_tracker.sv
module srpl_field_tracker
  import srpl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic rec_last
);
  logic [FLD_IDX_W-1:0] field_idx;
  logic [BPOS_W-1:0]    bit_pos;
  logic [BPOS_W-1:0]    width_m1;
  logic                 field_end;
  logic                 last_field;

  always_comb begin
    width_m1   = BPOS_W'(slot_width(int'(field_idx)) - 1);
    field_end  = (bit_pos == width_m1);
    last_field = (field_idx == FLD_IDX_W'(NUM_FIELDS - 1));
    rec_last   = take && field_end && last_field;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_idx <= '0;
      bit_pos   <= '0;
    end else if (take) begin
      if (field_end) begin
        bit_pos   <= '0;
        field_idx <= last_field ? '0 : field_idx + 1'b1;
      end else begin
        bit_pos <= bit_pos + 1'b1;
      end
    end
  end

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    field_idx <= FLD_IDX_W'(NUM_FIELDS - 1));

  assert_bit_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_pos <= width_m1);

  assert_still_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(bit_pos) && $stable(field_idx));
endmodule

// File: rtl/srpl_line_assembler.sv
module srpl_line_assembler
  import srpl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        bit_in,
  output cache_line_t line
);
  logic [REC_W-1:0]       rec;
  logic [NUM_LW*LW_W-1:0] lw_bus;
  logic [CTL_W-1:0]       ctl;

  // new bits enter at the top, so the first bit of the record ends at bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec <= '0;
    else if (take) rec <= {bit_in, rec[REC_W-1:1]};
  end

  for (genvar j = 0; j < NUM_LW; j++) begin : g_lw
    localparam int OFF = slot_offset(lw_slot(j));
    assign lw_bus[j*LW_W +: LW_W] = rec[OFF +: LW_W];
  end

  assign ctl = rec[slot_offset(SLOT_CTL) +: CTL_W];

  always_comb begin
    line.lws     = lw_bus;
    line.tag     = rec[slot_offset(SLOT_TAG) +: TAG_W];
    line.asn     = ctl[ASN_W-1:0];
    line.match   = ctl[ASN_W];
    line.line_ok = ctl[ASN_W+1];
    line.hist    = rec[slot_offset(SLOT_HIST) +: HIST_W];
  end

  assert_newest_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rec[REC_W-1] == $past(bit_in));
endmodule

// File: rtl/srpl_load_fsm.sv
module srpl_load_fsm
  import srpl_pkg::*;
#(
  parameter int NUM_LINES = 256,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_last,
  input  logic             wr_ready,
  output logic             take,
  output logic             rom_rst,
  output logic             wr_valid,
  output logic [IDX_W-1:0] wr_index,
  output logic             done
);
  load_state_t state, state_nx;
  logic        last_line;
  logic        accept;

  always_comb begin
    last_line = (wr_index == IDX_W'(NUM_LINES - 1));
    take      = (state == ST_LOAD);
    wr_valid  = (state == ST_PUSH);
    accept    = wr_valid && wr_ready;
    rom_rst   = (state == ST_BOOT) || (state == ST_DONE);
    done      = (state == ST_DONE);
    state_nx  = state;
    unique case (state)
      ST_BOOT: state_nx = ST_LOAD;
      ST_LOAD: if (rec_last) state_nx = ST_PUSH;
      ST_PUSH: if (accept) state_nx = last_line ? ST_DONE : ST_LOAD;
      ST_DONE: state_nx = ST_DONE;
      default: state_nx = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_BOOT;
      wr_index <= '0;
    end else begin
      state <= state_nx;
      if (accept && !last_line) wr_index <= wr_index + 1'b1;
    end
  end

  assert_no_shift_in_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && rom_rst));

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_index) && !take);

  assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !last_line |=> wr_index == $past(wr_index) + 1'b1);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_valid && wr_ready && last_line));

  assert_rom_low_in_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rom_rst);
endmodule

// File: rtl/sercache_preload.sv
module sercache_preload
  import srpl_pkg::*;
#(
  parameter int NUM_LINES = 256,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic                   rom_rst,
  output logic                   rom_shift,
  input  logic                   rom_bit,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [IDX_W-1:0]       wr_index,
  output logic [NUM_LW*LW_W-1:0] wr_lines,
  output logic [TAG_W-1:0]       wr_tag,
  output logic [ASN_W-1:0]       wr_asn,
  output logic                   wr_match,
  output logic                   wr_line_ok,
  output logic [HIST_W-1:0]      wr_hist,
  output logic                   done,
  output logic                   core_hold
);
  logic        take;
  logic        rec_last;
  cache_line_t line;

  srpl_field_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .rec_last (rec_last)
  );

  srpl_line_assembler u_asm (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .bit_in (rom_bit),
    .line   (line)
  );

  srpl_load_fsm #(.NUM_LINES(NUM_LINES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rec_last (rec_last),
    .wr_ready (wr_ready),
    .take     (take),
    .rom_rst  (rom_rst),
    .wr_valid (wr_valid),
    .wr_index (wr_index),
    .done     (done)
  );

  assign rom_shift  = take;
  assign core_hold  = !done;
  assign wr_lines   = line.lws;
  assign wr_tag     = line.tag;
  assign wr_asn     = line.asn;
  assign wr_match   = line.match;
  assign wr_line_ok = line.line_ok;
  assign wr_hist    = line.hist;

  assert_payload_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable(wr_lines) && $stable(wr_tag) && $stable(wr_hist)
      && $stable({wr_asn, wr_match, wr_line_ok}));

  assert_hold_inverse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_hold != done);
endmodule

// File: tb/sercache_preload_tb_top.sv
module sercache_preload_tb_top;
  localparam int LINES = 256;
  localparam int RECW  = 293;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rom_rst, rom_shift, rom_bit;
  logic         wr_valid, wr_ready, wr_match, wr_line_ok, done, core_hold;
  logic [7:0]   wr_index;
  logic [255:0] wr_lines;
  logic [20:0]  wr_tag;
  logic [5:0]   wr_asn;
  logic [7:0]   wr_hist;

  int n_chk = 0;
  int n_bad = 0;
  int rom_ptr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sercache_preload #(.NUM_LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n), .rom_rst(rom_rst), .rom_shift(rom_shift), .rom_bit(rom_bit),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_index(wr_index), .wr_lines(wr_lines),
    .wr_tag(wr_tag), .wr_asn(wr_asn), .wr_match(wr_match), .wr_line_ok(wr_line_ok),
    .wr_hist(wr_hist), .done(done), .core_hold(core_hold)
  );

  // expected line contents
  function automatic logic [31:0] e_lw(int l, int j);
    return 32'((l * 8 + j + 1) * 32'h9E3779B1) ^ 32'(l << 16);
  endfunction
  function automatic logic [20:0] e_tag(int l); return 21'(l * 7919) ^ 21'h15A5A5; endfunction
  function automatic logic [5:0] e_asn(int l); return 6'(l * 5 + 3); endfunction
  function automatic logic e_match(int l); return l[0]; endfunction
  function automatic logic e_ok(int l); return (l % 3) != 0; endfunction
  function automatic logic [7:0] e_hist(int l); return 8'(l) ^ 8'hC3; endfunction

  // serial record: first bit at index 0
  function automatic logic [RECW-1:0] rec_of(int l);
    logic [7:0] ctl;
    ctl = {e_ok(l), e_match(l), e_asn(l)};
    return {e_hist(l), e_lw(l, 7), e_lw(l, 5), e_lw(l, 3), e_lw(l, 1), ctl, e_tag(l),
            e_lw(l, 6), e_lw(l, 4), e_lw(l, 2), e_lw(l, 0)};
  endfunction

  // ROM model: next bit after each shift cycle, restart while held in reset
  always_ff @(posedge clk) begin
    if (rom_rst) rom_ptr <= 0;
    else if (rom_shift) rom_ptr <= rom_ptr + 1;
  end
  always_comb begin
    logic [RECW-1:0] r;
    r = rec_of(rom_ptr / RECW);
    rom_bit = rom_rst ? 1'b1 : r[rom_ptr % RECW];
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_reset_state();
    rst_n = 1'b0;
    wr_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(rom_rst == 1'b1, "R1 rom_rst in reset", 64'(rom_rst), 1);
    chk(rom_shift == 1'b0, "R2 no shift in reset", 64'(rom_shift), 0);
    chk(wr_valid == 1'b0, "R6 no write in reset", 64'(wr_valid), 0);
    chk(done == 1'b0 && core_hold == 1'b1, "R8 done/hold in reset", 64'({done, core_hold}), 64'b01);
    rst_n = 1'b1;
    chk(rom_rst == 1'b1, "R1 rom_rst first cycle", 64'(rom_rst), 1);
  endtask

  task automatic test_abort_restart();
    do_reset();
    repeat (700) @(negedge clk);
    chk(wr_index == 8'd2, "R6 index mid load", 64'(wr_index), 2);
    chk(rom_rst == 1'b0, "R1 rom low mid load", 64'(rom_rst), 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(wr_index == 8'd0 && rom_rst == 1'b1, "R9 reset clears load", 64'({wr_index, rom_rst}), 64'h1);
    rst_n = 1'b1;
  endtask

  task automatic check_line(input int l);
    chk(wr_index == 8'(l), "R6 index order", 64'(wr_index), 64'(l));
    for (int j = 0; j < 8; j++) begin
      chk(wr_lines[32*j +: 32] == e_lw(l, j), "R3 R4 longword", 64'(wr_lines[32*j +: 32]), 64'(e_lw(l, j)));
    end
    chk(wr_tag == e_tag(l), "R3 tag", 64'(wr_tag), 64'(e_tag(l)));
    chk(wr_asn == e_asn(l), "R5 asn", 64'(wr_asn), 64'(e_asn(l)));
    chk(wr_match == e_match(l), "R5 match", 64'(wr_match), 64'(e_match(l)));
    chk(wr_line_ok == e_ok(l), "R5 valid flag", 64'(wr_line_ok), 64'(e_ok(l)));
    chk(wr_hist == e_hist(l), "R3 history", 64'(wr_hist), 64'(e_hist(l)));
    chk(rom_rst == 1'b0, "R1 rom low while pushing", 64'(rom_rst), 0);
  endtask

  // full load from a fresh reset, with back-pressure on stall_line
  task automatic test_full_load(input int stall_line);
    int shifts;
    int bad_samp;
    logic [255:0] held;
    bad_samp = 0;
    for (int l = 0; l < LINES; l++) begin
      wr_ready = (l == stall_line) ? 1'b0 : 1'b1;
      shifts = 0;
      while (!wr_valid) begin
        if (rom_shift) shifts++;
        if (rom_shift && rom_rst) bad_samp++;
        @(negedge clk);
      end
      chk(shifts == RECW, "R2 bits per record", 64'(shifts), 64'(RECW));
      check_line(l);
      if (l == stall_line) begin
        held = wr_lines;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          chk(wr_valid && !rom_shift && wr_index == 8'(l) && wr_lines == held,
              "R7 stall hold", 64'({wr_valid, rom_shift}), 64'b10);
        end
        wr_ready = 1'b1;
      end
      chk(done == 1'b0, "R8 done low before final accept", 64'(done), 0);
      @(negedge clk);
    end
    chk(bad_samp == 0, "R2 no shift with rom_rst high", 64'(bad_samp), 0);
    chk(done == 1'b1, "R8 done one cycle after last write", 64'(done), 1);
    chk(core_hold == 1'b0, "R8 core released", 64'(core_hold), 0);
    chk(rom_rst == 1'b1, "R1 rom_rst after load", 64'(rom_rst), 1);
  endtask

  task automatic test_done_sticky();
    int extra;
    extra = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (wr_valid || rom_shift || !done || core_hold || !rom_rst) extra++;
    end
    chk(extra == 0, "R8 R6 R1 idle after done", 64'(extra), 0);
  endtask

  initial begin
    wr_ready = 1'b1;
    test_reset_state();
    test_abort_restart();
    test_full_load(1);
    test_done_sticky();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(180000 * 10);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule